// File: doc/BRIEF.md
# Asynchronous Access Ready-Timeout Monitor

This block sits beside an asynchronous external memory controller and watches how long each external transaction takes. A transaction is bracketed by a start pulse and an end pulse. Between them the controller may issue several narrow beats, for example when one wide bus access is split into byte-sized device cycles. The block counts clock cycles over the whole burst, not per beat. If the programmed cycle limit has been reached and the device is still holding off ready, the block tells the controller to terminate the transaction. It also raises an interrupt and records the address of the beat that stalled.

The block resolves readiness from two sources. One is a wait request from the memory. The other is a ready line from a second device. Both are resynchronized into the block's clock domain. While a transaction is open, the block also asserts a hold output that keeps the SDRAM refresh engine from starting a cycle. Software acknowledges the interrupt by writing one to a clear input. Until it does, the first captured fault address is preserved.

Top module: `async_ready_watchdog`

## Requirements
- R1: After reset, irq, fault_addr, refresh_hold and xfer_abort are all 0.
- R2: A timeout occurs in a cycle where a transaction is open, limit is nonzero, the elapsed count is at least limit, the synchronized stall is true and xfer_end is low. In that cycle xfer_abort is 1. On the next edge irq becomes 1 and fault_addr takes the address of the most recent beat. That address is the addr value at the start pulse, updated by each beat_strobe.
- R3: The elapsed count is cleared by the start pulse and beat strobes do not restart it. The count is 0 on the edge after start and gains one per clock. A burst whose xfer_end is sampled while the count equals limit finishes with no timeout, even when stalled throughout.
- R4: Stall is true when wait_req is 1 or dev_rdy is 0, each seen through a two-flop synchronizer. Without a stall, no timeout occurs however long the transaction runs.
- R5: A limit of 0 disables monitoring: no timeout and no interrupt.
- R6: irq stays 1 until a cycle with irq_clr high, after which it is 0. If a new timeout occurs in the same cycle as irq_clr, the timeout wins.
- R7: While irq is 1, a further timeout does not change fault_addr.
- R8: refresh_hold is 1 from the edge that accepts xfer_start until the edge that samples xfer_end or a timeout. A start pulse while a transaction is already open is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_start | input | 1 | Pulse opening an external transaction |
| xfer_end | input | 1 | Pulse marking completion of the whole burst |
| beat_strobe | input | 1 | Marks the start of a further beat; addr holds its address |
| wait_req | input | 1 | Asynchronous wait request, 1 = stall |
| dev_rdy | input | 1 | Asynchronous device ready, 0 = stall |
| addr | input | ADDR_W | Address of the current beat |
| limit | input | CNT_W | Timeout limit in cycles, 0 disables |
| irq_clr | input | 1 | Write-one-to-clear of the interrupt |
| irq | output | 1 | Pending timeout interrupt |
| fault_addr | output | ADDR_W | Address of the beat that timed out |
| refresh_hold | output | 1 | Holds off SDRAM refresh while a transaction is open |
| xfer_abort | output | 1 | Terminate request to the controller on timeout |

## Verification
The bench targets three bursts. The first is a four-beat burst that ends exactly when the count reaches the limit. A design that restarted the window per beat, or compared off by one, would either miss real timeouts or fire on this burst. The second burst stalls only on its last beat and overruns. It must report the last beat's address, which a design latching only the start address would get wrong. The third is a single access stalled through the ready line rather than the wait line, which exposes an inverted or missing ready source. The bench also covers a long burst with no stall, a zero limit, a second timeout while irq is pending (an overwriting design loses the first address), and the clear input.

// File: rtl/async_ready_watchdog.sv
module async_ready_watchdog #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_start,
  input  logic              xfer_end,
  input  logic              beat_strobe,
  input  logic              wait_req,
  input  logic              dev_rdy,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  limit,
  input  logic              irq_clr,
  output logic              irq,
  output logic [ADDR_W-1:0] fault_addr,
  output logic              refresh_hold,
  output logic              xfer_abort
);

  logic [1:0]        wait_sync, rdy_sync;
  logic              busy;
  logic [CNT_W-1:0]  elapsed;
  logic [ADDR_W-1:0] beat_addr;
  logic              stall;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wait_sync <= 2'b00;
      rdy_sync  <= 2'b11;
    end else begin
      wait_sync <= {wait_sync[0], wait_req};
      rdy_sync  <= {rdy_sync[0], dev_rdy};
    end

  assign stall = wait_sync[1] | ~rdy_sync[1];

  assign xfer_abort = busy && (limit != '0) && (elapsed >= limit) && stall && !xfer_end;
  assign refresh_hold = busy;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy      <= 1'b0;
      elapsed   <= '0;
      beat_addr <= '0;
    end else if (!busy) begin
      if (xfer_start) begin
        busy      <= 1'b1;
        elapsed   <= '0;
        beat_addr <= addr;
      end
    end else begin
      if (xfer_end || xfer_abort) busy <= 1'b0;
      else if (elapsed != '1) elapsed <= elapsed + 1'b1;
      if (beat_strobe) beat_addr <= addr;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      irq        <= 1'b0;
      fault_addr <= '0;
    end else begin
      if (xfer_abort) irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;
      if (xfer_abort && !irq) fault_addr <= beat_addr;
    end

  a_r2_abort_sets_irq: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_abort |=> irq);
  a_r2_abort_ends_hold: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_abort |=> !refresh_hold);
  a_r5_zero_limit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (limit == '0) |-> !xfer_abort);
  a_r6_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);
  a_r7_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> $stable(fault_addr));
  a_r8_end_drops_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_hold && xfer_end) |=> !refresh_hold);

endmodule

// File: tb/async_ready_watchdog_test.sv
`timescale 1ns/1ps
module async_ready_watchdog_test;
  localparam int AW = 32;
  localparam int CW = 16;

  logic clk = 0, rst_n = 0;
  logic xfer_start = 0, xfer_end = 0, beat_strobe = 0, wait_req = 0, dev_rdy = 1, irq_clr = 0;
  logic [AW-1:0] addr = '0;
  logic [CW-1:0] limit = 16'd20;
  logic irq, refresh_hold, xfer_abort;
  logic [AW-1:0] fault_addr;

  int checks = 0, errors = 0;
  bit finished = 0;

  typedef struct { bit irq; logic [AW-1:0] fa; string tag; } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  async_ready_watchdog #(.ADDR_W(AW), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_end(xfer_end),
    .beat_strobe(beat_strobe), .wait_req(wait_req), .dev_rdy(dev_rdy), .addr(addr),
    .limit(limit), .irq_clr(irq_clr), .irq(irq), .fault_addr(fault_addr),
    .refresh_hold(refresh_hold), .xfer_abort(xfer_abort));

  task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected results and compares against the outputs.
  initial forever begin
    exp_t e;
    wait (sb.size() != 0);
    e = sb.pop_front();
    check({e.tag, " irq"}, {31'b0, irq}, {31'b0, e.irq});
    check({e.tag, " fault_addr"}, fault_addr, e.fa);
    check({e.tag, " hold released"}, {31'b0, refresh_hold}, 32'b0);
  end

  // Driver: beats every gap cycles, stall from cycle stall_from, end driven at cycle total.
  task automatic txn(input logic [AW-1:0] base, input int beats, input int gap,
                     input int stall_from, input bit via_rdy, input int total,
                     input bit exp_irq, input logic [AW-1:0] exp_fa, input string tag);
    @(negedge clk);
    xfer_start = 1; addr = base;
    for (int k = 1; k <= total; k++) begin
      @(negedge clk);
      xfer_start = 0; beat_strobe = 0; xfer_end = 0;
      if (k == 2) check({tag, " R8 hold during access"}, {31'b0, refresh_hold}, 32'd1);
      for (int b = 1; b < beats; b++)
        if (k == b * gap) begin beat_strobe = 1; addr = base + b; end
      if (stall_from > 0 && k >= stall_from) begin
        if (via_rdy) dev_rdy = 0; else wait_req = 1;
      end
      if (k == total) xfer_end = 1;
    end
    @(negedge clk);
    xfer_end = 0; beat_strobe = 0; wait_req = 0; dev_rdy = 1;
    repeat (3) @(negedge clk);
    sb.push_back('{exp_irq, exp_fa, tag});
    wait (sb.size() == 0);
  endtask

  task automatic clear_irq();
    @(negedge clk); irq_clr = 1;
    @(negedge clk); irq_clr = 0;
    check("R6 irq cleared by write-one", {31'b0, irq}, 32'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 irq at reset", {31'b0, irq}, 32'b0);
    check("R1 fault_addr at reset", fault_addr, 32'b0);
    check("R1 hold at reset", {31'b0, refresh_hold}, 32'b0);
    check("R1 abort at reset", {31'b0, xfer_abort}, 32'b0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // R3: 4-beat burst stalled on last beat, ends when count equals limit
    txn(32'h1000_0000, 4, 5, 16, 0, 21, 0, 32'h0, "R3 burst inside window");
    // R4: no stall, far past limit
    txn(32'h2000_0000, 4, 5, 0, 0, 60, 0, 32'h0, "R4 no stall past limit");
    // R2: same burst one cycle longer overruns on its last beat
    txn(32'h3000_0000, 4, 5, 16, 0, 22, 1, 32'h3000_0003, "R2 overrun on last beat");
    // R7: second timeout while pending keeps first address
    txn(32'h4000_0000, 1, 5, 1, 1, 40, 1, 32'h3000_0003, "R7 address kept while pending");
    clear_irq();
    // R4: single access stalled by the device-ready line
    txn(32'h5000_0040, 1, 5, 1, 1, 40, 1, 32'h5000_0040, "R4 single access ready stall");
    clear_irq();
    // R5: limit zero disables monitoring
    limit = '0;
    txn(32'h6000_0000, 1, 5, 1, 0, 60, 0, 32'h5000_0040, "R5 zero limit");
    limit = 16'd20;
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      repeat (100000) @(posedge clk);
    join_any
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule